// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous host to an external asynchronous static RAM of 512K words by 16 bits. The host presents one request at a time on a valid/ready port: a 19-bit word address, a read/write flag, 16 bits of write data and two byte enables. The controller turns each request into a complete memory cycle. It drives both chip enables (one active low, one active high), the write enable, the output enable and the two byte-lane strobes. It also drives the address and the output half of the data bus, together with a drive-enable for the pad's tri-state buffer. Read data arrives on a separate input.

All memory timing is counted in system clock cycles. The counts are computed at elaboration by ceiling division of nanosecond parameters by the clock period. Writes are controlled by the write-enable strobe, and the address and chip enables are held still while that strobe is low. The device is deselected for at least one cycle between any two accesses, so every change between a read and a write comes with a chip-enable toggle. After each read, extra deselected cycles give the memory's outputs time to float before the controller can drive the bus again.

With the default 10 ns clock, the counts are: read access 6 cycles, write pulse 6 cycles, drive delay after the write strobe falls 3 cycles, and read turnaround 3 cycles.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is low and whenever the controller is idle, the outputs are: first chip enable 1, second chip enable 0, write enable 1, output enable 1, both byte strobes 1, data drive-enable 0, read-data-valid 0 and request-ready 1.
- R2: Request-ready is high only when idle. A request is taken on a clock edge where valid and ready are both high. In the next cycle the device is selected (first enable 0, second enable 1) and the memory address output equals the request address.
- R3: A read keeps output enable at 0 and write enable at 1 for RD_CYC cycles, with the data bus not driven. RD_CYC = ceil(max(read cycle ns, access ns) / clock ns), which is 6 by default.
- R4: Read data is sampled at the clock edge that ends the last output-enable-low cycle. In the following cycle, read-data-valid is high for exactly one cycle, carrying that data, and the device is deselected.
- R5: The lower strobe is the inverse of byte enable bit 0 and gates data bits 7:0. The upper strobe is the inverse of bit 1 and gates bits 15:8. Both strobes are high whenever the device is deselected. In read data, a byte lane whose enable is 0 reads as 8'h00.
- R6: A write starts with one setup cycle: device selected, write enable 1, output enable 1, bus not driven. Write enable is then 0 for WP_CYC = max(ceil(pulse ns), ceil(address-to-end ns), HZ_CYC + ceil(data setup ns)) cycles, which is 6 by default.
- R7: The bus stays undriven for the first HZ_CYC = ceil(output-float ns / clock ns) cycles of write enable low (3 by default). It is driven with the write data for the remaining low cycles. It also stays driven for one recovery cycle after write enable rises, in which the device stays selected.
- R8: While write enable is 0, the address and both chip enables do not change. The address changes only while write enable is 1.
- R9: After a read's valid cycle, the device stays deselected for TA_CYC = ceil(output-off ns / clock ns) cycles (3 by default) before ready returns. After the write recovery cycle, ready returns in the next cycle. Every access begins from a deselected cycle.
- R10: Write enable and output enable are never low together, and the bus is never driven while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables, bit 0 = bits 7:0 |
| rsp_valid_o | output | 1 | Read data valid, one cycle |
| rsp_rdata_o | output | 16 | Read data, disabled lanes zero |
| mem_addr_o | output | 19 | Memory address |
| mem_ce1_no | output | 1 | Chip enable, active low |
| mem_ce2_o | output | 1 | Chip enable, active high |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_lb_no | output | 1 | Lower byte strobe, active low |
| mem_ub_no | output | 1 | Upper byte strobe, active low |
| mem_dq_o | output | 16 | Data to the memory pads |
| mem_dq_oe_o | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 16 | Data from the memory pads |

## Verification
Some properties are checked on every cycle by assertions. These cover:
- that write and output enables are never low together;
- that the bus is never driven against output enable;
- that the address and enables are frozen during the write pulse;
- the exact lengths of the output-enable and write-enable pulses;
- the length of the driven part of the write pulse, measured with counters;
- the single-cycle valid pulse;
- that every read begins from a deselected cycle.

The bench's scenarios show the rest:
- that the data reaching memory and returned to the host is correct;
- lane masking, including writes with no lanes enabled;
- boundary addresses;
- the exact cycle each strobe moves, compared against a reference timeline built from the requirements.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_ACCESS  = 3'd1,
    ST_RD_DONE    = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_RECOVER = 3'd5,
    ST_TURN       = 3'd6
  } state_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  // cycles spent in current state, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clear_i)       cnt_q <= '0;
    else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 16,
  parameter int unsigned NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NB-1:0] be_i,
  input  logic          capture_i,
  input  logic [DW-1:0] dq_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [NB-1:0] be_o,
  output logic [DW-1:0] rdata_o
);

  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [NB-1:0] be_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (load_i) begin
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  // per-lane capture, disabled lanes forced to zero
  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rdata_q[8*g +: 8] <= '0;
      else if (capture_i) rdata_q[8*g +: 8] <= be_q[g] ? dq_i[8*g +: 8] : 8'h00;
    end
  end

  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign be_o    = be_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 6,
  parameter int unsigned WP_CYC = 6,
  parameter int unsigned HZ_CYC = 3,
  parameter int unsigned TA_CYC = 3,
  parameter int unsigned CNT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clear_o,
  output logic             ready_o,
  output logic             capture_o,
  output logic             sel_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             drive_o,
  output logic             rsp_valid_o
);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LAST = CNT_W'(TA_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_CNT  = CNT_W'(HZ_CYC);

  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (req_valid_i) state_d = req_we_i ? ST_WR_SETUP : ST_RD_ACCESS;
      ST_RD_ACCESS:  if (cnt_i == RD_LAST) state_d = ST_RD_DONE;
      ST_RD_DONE:    state_d = ST_TURN;
      ST_TURN:       if (cnt_i == TA_LAST) state_d = ST_IDLE;
      ST_WR_SETUP:   state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (cnt_i == WP_LAST) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign clear_o     = (state_d != state_q);
  assign ready_o     = (state_q == ST_IDLE);
  assign capture_o   = (state_q == ST_RD_ACCESS) && (cnt_i == RD_LAST);
  assign sel_o       = (state_q == ST_RD_ACCESS) || (state_q == ST_WR_SETUP) ||
                       (state_q == ST_WR_PULSE)  || (state_q == ST_WR_RECOVER);
  assign we_n_o      = (state_q != ST_WR_PULSE);
  assign oe_n_o      = (state_q != ST_RD_ACCESS);
  assign drive_o     = ((state_q == ST_WR_PULSE) && (cnt_i >= HZ_CNT)) ||
                       (state_q == ST_WR_RECOVER);
  assign rsp_valid_o = (state_q == ST_RD_DONE);

  // pulse-width monitors for the checks below
  logic [CNT_W-1:0] we_low_q, oe_low_q, drv_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_q  <= '0;
      oe_low_q  <= '0;
      drv_low_q <= '0;
    end else begin
      we_low_q  <= !we_n_o ? we_low_q + 1'b1 : '0;
      oe_low_q  <= !oe_n_o ? oe_low_q + 1'b1 : '0;
      drv_low_q <= !we_n_o ? (drive_o ? drv_low_q + 1'b1 : drv_low_q) : '0;
    end
  end

  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!sel_o && we_n_o && oe_n_o && !drive_o)); // R2
  AST_ACCEPT_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o) |=> sel_o); // R2
  AST_OE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_n_o) |-> (oe_low_q == CNT_W'(RD_CYC))); // R3
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R4
  AST_RSP_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !sel_o); // R4
  AST_WE_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_o) |-> ($past(sel_o) && $past(oe_n_o) && !$past(drive_o))); // R6
  AST_WE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> (we_low_q == CNT_W'(WP_CYC))); // R6
  AST_WE_FALL_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_o) |-> !drive_o); // R7
  AST_DRIVE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> (drv_low_q == CNT_W'(WP_CYC - HZ_CYC)) && drive_o && sel_o); // R7
  AST_RD_FROM_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_n_o) |-> !$past(sel_o)); // R9
  AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_n_o && !oe_n_o)); // R10
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> oe_n_o); // R10

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_RC_NS  = 55,
  parameter int unsigned T_AA_NS  = 55,
  parameter int unsigned T_WP_NS  = 30,
  parameter int unsigned T_AW_NS  = 55,
  parameter int unsigned T_DW_NS  = 25,
  parameter int unsigned T_WHZ_NS = 25,
  parameter int unsigned T_OHZ_NS = 25,
  parameter int unsigned AW       = 19,
  parameter int unsigned DW       = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [1:0]    req_be_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce1_no,
  output logic          mem_ce2_o,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic          mem_lb_no,
  output logic          mem_ub_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int unsigned NB     = 2;
  localparam int unsigned RD_CYC = max2(max2(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)), 1);
  localparam int unsigned HZ_CYC = ns2cyc(T_WHZ_NS, CLK_NS);
  localparam int unsigned WP_CYC = max2(max2(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                        HZ_CYC + max2(ns2cyc(T_DW_NS, CLK_NS), 1));
  localparam int unsigned TA_CYC = max2(ns2cyc(T_OHZ_NS, CLK_NS), 1);
  localparam int unsigned CNT_MAX = max2(max2(RD_CYC, WP_CYC), TA_CYC);
  localparam int unsigned CNT_W  = $clog2(CNT_MAX + 1) + 1;

  logic             clear, capture, sel, drive, load, we_lat;
  logic [CNT_W-1:0] cnt;
  logic [NB-1:0]    be_lat;
  logic [NB-1:0]    strobe_n;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .cnt_o   (cnt)
  );

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .HZ_CYC (HZ_CYC),
    .TA_CYC (TA_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .cnt_i       (cnt),
    .clear_o     (clear),
    .ready_o     (req_ready_o),
    .capture_o   (capture),
    .sel_o       (sel),
    .we_n_o      (mem_we_no),
    .oe_n_o      (mem_oe_no),
    .drive_o     (drive),
    .rsp_valid_o (rsp_valid_o)
  );

  assign load = req_valid_i && req_ready_o;

  sram_ctrl_dp #(.AW(AW), .DW(DW), .NB(NB)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .we_i      (req_we_i),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .be_i      (req_be_i),
    .capture_i (capture),
    .dq_i      (mem_dq_i),
    .we_o      (we_lat),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_dq_o),
    .be_o      (be_lat),
    .rdata_o   (rsp_rdata_o)
  );

  for (genvar g = 0; g < NB; g++) begin : g_strobe
    assign strobe_n[g] = !(sel && be_lat[g]);
  end

  assign mem_ce1_no  = !sel;
  assign mem_ce2_o   = sel;
  assign mem_lb_no   = strobe_n[0];
  assign mem_ub_no   = strobe_n[NB-1];
  assign mem_dq_oe_o = drive;

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && $past(!mem_we_no)) |->
      ($stable(mem_addr_o) && $stable(mem_ce1_no) && $stable(mem_ce2_o))); // R8
  AST_ADDR_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> (mem_we_no && $past(mem_we_no))); // R8
  AST_LANES_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce1_no |-> (mem_lb_no && mem_ub_no && !mem_dq_oe_o)); // R5
  AST_DRIVE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> we_lat); // R7

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RD  = 6;   // ceil(55/10)
  localparam int HZ  = 3;   // ceil(25/10)
  localparam int WP  = 6;   // max(3, 6, 3+3)
  localparam int TA  = 3;   // ceil(25/10)
  localparam int WD_LIMIT = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid_i, req_we_i;
  logic [18:0] req_addr_i;
  logic [15:0] req_wdata_i;
  logic [1:0]  req_be_i;
  logic        req_ready_o, rsp_valid_o;
  logic [15:0] rsp_rdata_o;
  logic [18:0] mem_addr_o;
  logic        mem_ce1_no, mem_ce2_o, mem_we_no, mem_oe_no, mem_lb_no, mem_ub_no;
  logic [15:0] mem_dq_o, mem_dq_i;
  logic        mem_dq_oe_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sram_ctrl u_sram_ctrl (.*);

  // ---- pin-level memory model ----
  logic [15:0] pin_mem  [logic [18:0]];
  logic [15:0] gold_mem [logic [18:0]];

  function automatic logic [15:0] dflt(logic [18:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] pin_rd(logic [18:0] a);
    return pin_mem.exists(a) ? pin_mem[a] : dflt(a);
  endfunction

  wire pin_sel = !mem_ce1_no && mem_ce2_o;
  wire pin_rd_en = pin_sel && !mem_oe_no && mem_we_no;
  logic [15:0] pin_word;
  assign pin_word = pin_rd(mem_addr_o);
  assign mem_dq_i = pin_rd_en ? {mem_ub_no ? 8'hEE : pin_word[15:8],
                                 mem_lb_no ? 8'hEE : pin_word[7:0]} : 16'hEEEE;

  always @(posedge clk_i) begin
    if (rst_ni && pin_sel && !mem_we_no && mem_dq_oe_o) begin
      logic [15:0] w;
      w = pin_rd(mem_addr_o);
      if (!mem_lb_no) w[7:0]  = mem_dq_o[7:0];
      if (!mem_ub_no) w[15:8] = mem_dq_o[15:8];
      pin_mem[mem_addr_o] = w;
    end
  end

  // ---- reference timeline ----
  typedef struct {
    bit        sel, we_n, oe_n, lb_n, ub_n, dq_oe, rsp, rdy;
    bit [18:0] addr;
    bit [15:0] wd, rd;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_err = 0, cyc = 0;
  bit   last_idle;

  function automatic exp_t idle_e();
    exp_t e;
    e = '{sel:0, we_n:1, oe_n:1, lb_n:1, ub_n:1, dq_oe:0, rsp:0, rdy:1, addr:0, wd:0, rd:0};
    return e;
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  task automatic step();
    exp_t e;
    string t;
    @(negedge clk_i);
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_err++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WD_LIMIT);
      summary();
    end
    e = (q.size() != 0) ? q.pop_front() : idle_e();
    last_idle = e.rdy;
    t = e.rdy ? "R1" : "R2";
    cmp(t,    "ce1_n", 32'(mem_ce1_no), 32'(!e.sel));
    cmp(t,    "ce2",   32'(mem_ce2_o),  32'(e.sel));
    cmp("R6", "we_n",  32'(mem_we_no),  32'(e.we_n));
    cmp("R3", "oe_n",  32'(mem_oe_no),  32'(e.oe_n));
    cmp("R5", "lb_n",  32'(mem_lb_no),  32'(e.lb_n));
    cmp("R5", "ub_n",  32'(mem_ub_no),  32'(e.ub_n));
    cmp("R7", "dq_oe", 32'(mem_dq_oe_o), 32'(e.dq_oe));
    cmp("R4", "rsp_valid", 32'(rsp_valid_o), 32'(e.rsp));
    cmp("R9", "ready", 32'(req_ready_o), 32'(e.rdy));
    if (e.sel)   cmp("R8", "addr",  32'(mem_addr_o),  32'(e.addr));
    if (e.dq_oe) cmp("R7", "wdata", 32'(mem_dq_o),    32'(e.wd));
    if (e.rsp)   cmp("R4 R5", "rdata", 32'(rsp_rdata_o), 32'(e.rd));
  endtask

  function automatic logic [15:0] gold_rd(logic [18:0] a);
    return gold_mem.exists(a) ? gold_mem[a] : dflt(a);
  endfunction

  task automatic issue(bit we, logic [18:0] a, logic [15:0] d, logic [1:0] be);
    exp_t e;
    while (!last_idle) step();
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = d; req_be_i = be;
    e = idle_e();
    e.rdy = 0; e.addr = a; e.wd = d;
    if (!we) begin
      logic [15:0] g;
      g = gold_rd(a);
      for (int i = 0; i < RD; i++) begin
        e.sel = 1; e.oe_n = 0; e.lb_n = !be[0]; e.ub_n = !be[1];
        q.push_back(e);
      end
      e = idle_e(); e.rdy = 0; e.rsp = 1;
      e.rd = {be[1] ? g[15:8] : 8'h00, be[0] ? g[7:0] : 8'h00};
      q.push_back(e);
      e = idle_e(); e.rdy = 0;
      for (int i = 0; i < TA; i++) q.push_back(e);
    end else begin
      logic [15:0] g;
      e.sel = 1; e.lb_n = !be[0]; e.ub_n = !be[1];
      q.push_back(e);                               // setup
      for (int i = 0; i < WP; i++) begin
        e.we_n = 0; e.dq_oe = (i >= HZ);
        q.push_back(e);
      end
      e.we_n = 1; e.dq_oe = 1;
      q.push_back(e);                               // recovery
      g = gold_rd(a);
      if (be[0]) g[7:0]  = d[7:0];
      if (be[1]) g[15:8] = d[15:8];
      gold_mem[a] = g;
    end
    step();
    req_valid_i = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0; req_valid_i = 1'b0; req_we_i = 1'b0;
    req_addr_i = '0; req_wdata_i = '0; req_be_i = '0;
    step(); step();                      // R1 reset state
    rst_ni = 1'b1;
    step();
    issue(1, 19'h00123, 16'hA55A, 2'b11);  // R6 R7 full write
    issue(0, 19'h00123, 16'h0000, 2'b11);  // R3 R4 read back
    issue(1, 19'h00123, 16'h7E00, 2'b10);  // R5 upper lane only
    issue(0, 19'h00123, 16'h0000, 2'b11);
    issue(0, 19'h00123, 16'h0000, 2'b01);  // R5 lower lane, upper zero
    issue(0, 19'h00123, 16'h0000, 2'b00);  // R5 no lanes
    issue(1, 19'h00123, 16'hFFFF, 2'b00);  // R5 write with no lanes
    issue(0, 19'h00123, 16'h0000, 2'b11);
    issue(0, 19'h0ABCD, 16'h0000, 2'b11);  // unwritten word
    issue(1, 19'h7FFFF, 16'h1234, 2'b11);  // R8 top address
    issue(1, 19'h00000, 16'h8001, 2'b01);  // back-to-back writes
    issue(0, 19'h7FFFF, 16'h0000, 2'b11);  // R9 write->read toggle
    issue(0, 19'h00000, 16'h0000, 2'b11);
    issue(1, 19'h00000, 16'hC300, 2'b10);  // read->write turnaround
    issue(0, 19'h00000, 16'h0000, 2'b11);
    for (int i = 0; i < 16; i++) step();
    summary();
  end

endmodule